// File: doc/BRIEF.md
# Ordered Region Bus Decoder

This block routes the accesses of one bus master to one of several slaves. Each slave owns one contiguous window of the address space. A window is given by a base and a length, both fixed when the design is elaborated. The windows are listed in ascending base order and must not overlap. If an index search ever finds more than one hit, the lowest-indexed window wins. The total decoded span ends at the base plus the length of the last window.

The master starts an access with a one-cycle `start` pulse. The pulse carries an address, a byte count of 1, 2 or 4, a write flag and write data. The decoder checks the whole byte span against the map:

- **Legal access.** The decoder selects the matching slave and gives it the address minus that window's base. It holds that select until the slave answers, then returns a one-cycle done response with the read data.
- **Illegal access.** The decoder selects no slave and returns a one-cycle fault response with a cause code. An access is illegal if its byte count is illegal, if its start address is in no window, or if its last byte runs past the end of the window it starts in.

The default map has three windows:

| Window | Index | Base | Length |
|---|---|---|---|
| Boot ROM | 0 | 0x000000 | 64 KiB |
| RAM | 1 | 0x100000 | 1 MiB |
| Peripheral | 2 | 0x700000 | 16 bytes |

The controller has four states:

- **ST_IDLE.** Waits for `start`. A start goes to ST_BUSY if the access is legal (transition *accept*) and to ST_FAULT if it is not (transition *reject*).
- **ST_BUSY.** Drives the select until the selected slave raises ready (transition *complete*), then goes to ST_DONE.
- **ST_DONE.** Presents the done response for one cycle, then returns to ST_IDLE (transition *retire*).
- **ST_FAULT.** Presents the fault response for one cycle, then returns to ST_IDLE (transition *recover*).

Top module: `bus_region_decoder`

## Requirements
- R1: After reset no slave is selected, and `m_done`, `m_fault` and `m_fault_cause` are all 0.
- R2: A legal access whose start address lies in window i (base ≤ address < base+length) raises bit i of `s_sel`, and only that bit, in the cycle after `start`. Window indices follow the default map: ROM is 0, RAM is 1, peripheral is 2.
- R3: While a slave is selected, `s_addr` equals the access address minus that window's base, and `s_nbytes` equals the requested byte count.
- R4: An access whose relative address plus byte count exceeds the window length gives a fault with cause 2 (overrun) and selects no slave.
- R5: An access whose start address lies in no window gives a fault with cause 1 (unmapped) and selects no slave. This covers gaps between windows and addresses beyond the decoded span.
- R6: A byte count other than 1, 2 or 4 gives a fault with cause 3 (bad length), whatever the address.
- R7: A fault is signalled as `m_fault`=1 for exactly one cycle, in the cycle after `start`. `m_fault_cause` is 0 whenever `m_fault` is 0.
- R8: The select, `s_addr` and `s_wdata` stay stable until the selected slave raises `s_ready`. In the following cycle `m_done` is 1 for exactly one cycle, and `m_rdata` holds that slave's read data.
- R9: For a write, `s_we` is 1 and `s_wdata` carries the master's write data while the slave is selected. For a read, `s_we` is 0.
- R10: A `start` pulse that arrives while an access is in progress is ignored and does not change the selected slave or its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_start | input | 1 | One-cycle access request |
| m_addr | input | ADDR_W | Access start address |
| m_nbytes | input | 3 | Byte count (1, 2 or 4 legal) |
| m_we | input | 1 | 1 = write, 0 = read |
| m_wdata | input | DATA_W | Write data |
| m_rdata | output | DATA_W | Read data, valid with m_done |
| m_done | output | 1 | One-cycle completion response |
| m_fault | output | 1 | One-cycle error response |
| m_fault_cause | output | 2 | 0 none, 1 unmapped, 2 overrun, 3 bad length |
| s_sel | output | NUM_REG | One-hot slave select |
| s_addr | output | ADDR_W | Address relative to the selected window's base |
| s_nbytes | output | 3 | Byte count to the slave |
| s_we | output | 1 | Write flag to the slave |
| s_wdata | output | DATA_W | Write data to the slave |
| s_rdata | input | NUM_REG*DATA_W | Read data, slave i in bits [i*DATA_W +: DATA_W] |
| s_ready | input | NUM_REG | Per-slave completion |

## Verification
The assertions check the following on every cycle:

- The select is one-hot or zero.
- A selected slave's relative address plus byte count never leaves its window.
- A fault never comes with a select, and a fault lasts a single cycle.
- The select and address hold steady while the slave has not answered.
- A slave's ready is always followed by a done response.

Only the bench scenarios can show the rest:

- Which window a given address lands in, and the exact relative address.
- The cause codes at the window edges and the priority of a bad length over an unmapped address.
- That a start pulse arriving mid-access is ignored.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } dec_state_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'd0,
        FC_UNMAPPED = 2'd1,
        FC_OVERRUN  = 2'd2,
        FC_BADLEN   = 2'd3
    } fault_cause_e;

    localparam int unsigned DEF_ADDR_W = 24;
    localparam int unsigned DEF_NUM_REG = 3;

    localparam logic [DEF_ADDR_W-1:0] DEF_ROM_BASE = 24'h000000;
    localparam logic [DEF_ADDR_W-1:0] DEF_ROM_LEN  = 24'h010000;
    localparam logic [DEF_ADDR_W-1:0] DEF_RAM_BASE = 24'h100000;
    localparam logic [DEF_ADDR_W-1:0] DEF_RAM_LEN  = 24'h100000;
    localparam logic [DEF_ADDR_W-1:0] DEF_IO_BASE  = 24'h700000;
    localparam logic [DEF_ADDR_W-1:0] DEF_IO_LEN   = 24'h000010;

    function automatic logic nbytes_legal(input logic [2:0] n);
        return (n == 3'd1) || (n == 3'd2) || (n == 3'd4);
    endfunction

endpackage

// File: rtl/region_window.sv
module region_window #(
    parameter int unsigned           ADDR_W = 24,
    parameter logic [ADDR_W-1:0]     BASE   = '0,
    parameter logic [ADDR_W-1:0]     LEN    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        nbytes,
    output logic              hit,
    output logic              overrun,
    output logic [ADDR_W-1:0] rel
);
    localparam logic [ADDR_W:0] BASE_X = {1'b0, BASE};
    localparam logic [ADDR_W:0] END_X  = {1'b0, BASE} + {1'b0, LEN};
    localparam logic [ADDR_W:0] LEN_X  = {1'b0, LEN};

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] span_end;

    always_comb begin
        addr_x   = {1'b0, addr};
        hit      = (addr_x >= BASE_X) && (addr_x < END_X);
        rel      = addr - BASE;
        span_end = {1'b0, rel} + {{(ADDR_W-2){1'b0}}, nbytes};
        overrun  = hit && (span_end > LEN_X);
    end
endmodule

// File: rtl/first_hit_picker.sv
module first_hit_picker #(
    parameter int unsigned N     = 3,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     hits,
    output logic             any_hit,
    output logic [IDX_W-1:0] win_idx
);
    always_comb begin
        any_hit = |hits;
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) win_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dec_sequencer.sv
module dec_sequencer
    import busdec_pkg::*;
#(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_REG = 3,
    parameter int unsigned IDX_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      dec_any,
    input  logic                      dec_overrun,
    input  logic                      dec_len_ok,
    input  logic [IDX_W-1:0]          dec_idx,
    input  logic [ADDR_W-1:0]         dec_rel,
    input  logic [2:0]                req_nbytes,
    input  logic                      req_we,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic [NUM_REG-1:0]        s_ready,
    input  logic [NUM_REG*DATA_W-1:0] s_rdata,
    output logic [NUM_REG-1:0]        s_sel,
    output logic [ADDR_W-1:0]         s_addr,
    output logic [2:0]                s_nbytes,
    output logic                      s_we,
    output logic [DATA_W-1:0]         s_wdata,
    output logic                      m_done,
    output logic [DATA_W-1:0]         m_rdata,
    output logic                      m_fault,
    output logic [1:0]                m_fault_cause
);
    dec_state_e   state_q, state_d;
    fault_cause_e cause_q, cause_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] rel_q;
    logic [2:0]        nb_q;
    logic              we_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;
    logic              sel_ready;

    assign sel_ready = s_ready[idx_q];

    // next-state decision
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!dec_len_ok) begin
                        state_d = ST_FAULT;
                        cause_d = FC_BADLEN;
                    end else if (!dec_any) begin
                        state_d = ST_FAULT;
                        cause_d = FC_UNMAPPED;
                    end else if (dec_overrun) begin
                        state_d = ST_FAULT;
                        cause_d = FC_OVERRUN;
                    end else begin
                        state_d = ST_BUSY;
                        cause_d = FC_NONE;
                    end
                end
            end
            ST_BUSY:  if (sel_ready) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= FC_NONE;
            idx_q   <= '0;
            rel_q   <= '0;
            nb_q    <= '0;
            we_q    <= 1'b0;
            wd_q    <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            if (state_q == ST_IDLE && start) begin
                idx_q <= dec_idx;
                rel_q <= dec_rel;
                nb_q  <= req_nbytes;
                we_q  <= req_we;
                wd_q  <= req_wdata;
            end
            if (state_q == ST_BUSY && sel_ready) begin
                rd_q <= s_rdata[idx_q*DATA_W +: DATA_W];
            end
        end
    end

    // outputs from state
    always_comb begin
        s_sel         = '0;
        s_addr        = '0;
        s_nbytes      = '0;
        s_we          = 1'b0;
        s_wdata       = '0;
        m_done        = 1'b0;
        m_rdata       = '0;
        m_fault       = 1'b0;
        m_fault_cause = FC_NONE;
        unique case (state_q)
            ST_IDLE: ;
            ST_BUSY: begin
                s_sel[idx_q] = 1'b1;
                s_addr       = rel_q;
                s_nbytes     = nb_q;
                s_we         = we_q;
                s_wdata      = wd_q;
            end
            ST_DONE: begin
                m_done  = 1'b1;
                m_rdata = rd_q;
            end
            ST_FAULT: begin
                m_fault       = 1'b1;
                m_fault_cause = cause_q;
            end
            default: ;
        endcase
    end

    assert_fault_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_fault |=> !m_fault);

    assert_cause_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !m_fault |-> (m_fault_cause == 2'd0));

    assert_no_sel_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_fault |-> (s_sel == '0));

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_sel));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_sel != '0) && ((s_sel & s_ready) == '0)) |=>
            ($stable(s_sel) && $stable(s_addr) && $stable(s_wdata)));

    assert_done_after_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_sel & s_ready) != '0) |=> (m_done && !m_fault));

    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_done |=> !m_done);
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
    import busdec_pkg::*;
#(
    parameter int unsigned       ADDR_W  = DEF_ADDR_W,
    parameter int unsigned       DATA_W  = 32,
    parameter int unsigned       NUM_REG = DEF_NUM_REG,
    parameter logic [ADDR_W-1:0] REG_BASE [NUM_REG] = '{DEF_ROM_BASE, DEF_RAM_BASE, DEF_IO_BASE},
    parameter logic [ADDR_W-1:0] REG_LEN  [NUM_REG] = '{DEF_ROM_LEN, DEF_RAM_LEN, DEF_IO_LEN}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      m_start,
    input  logic [ADDR_W-1:0]         m_addr,
    input  logic [2:0]                m_nbytes,
    input  logic                      m_we,
    input  logic [DATA_W-1:0]         m_wdata,
    output logic [DATA_W-1:0]         m_rdata,
    output logic                      m_done,
    output logic                      m_fault,
    output logic [1:0]                m_fault_cause,
    output logic [NUM_REG-1:0]        s_sel,
    output logic [ADDR_W-1:0]         s_addr,
    output logic [2:0]                s_nbytes,
    output logic                      s_we,
    output logic [DATA_W-1:0]         s_wdata,
    input  logic [NUM_REG*DATA_W-1:0] s_rdata,
    input  logic [NUM_REG-1:0]        s_ready
);
    localparam int unsigned IDX_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;
    localparam logic [ADDR_W:0] SPAN_END =
        {1'b0, REG_BASE[NUM_REG-1]} + {1'b0, REG_LEN[NUM_REG-1]};

    logic [NUM_REG-1:0] hit_vec;
    logic [NUM_REG-1:0] ovr_vec;
    logic [ADDR_W-1:0]  rel_vec [NUM_REG];
    logic               any_hit;
    logic [IDX_W-1:0]   win_idx;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_win
        region_window #(
            .ADDR_W (ADDR_W),
            .BASE   (REG_BASE[g]),
            .LEN    (REG_LEN[g])
        ) u_win (
            .addr    (m_addr),
            .nbytes  (m_nbytes),
            .hit     (hit_vec[g]),
            .overrun (ovr_vec[g]),
            .rel     (rel_vec[g])
        );

        assert_rel_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
            s_sel[g] |-> (({1'b0, s_addr} + {{(ADDR_W-2){1'b0}}, s_nbytes})
                          <= {1'b0, REG_LEN[g]}));
    end

    first_hit_picker #(
        .N     (NUM_REG),
        .IDX_W (IDX_W)
    ) u_pick (
        .hits    (hit_vec),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    dec_sequencer #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_REG (NUM_REG),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (m_start),
        .dec_any       (any_hit),
        .dec_overrun   (ovr_vec[win_idx]),
        .dec_len_ok    (nbytes_legal(m_nbytes)),
        .dec_idx       (win_idx),
        .dec_rel       (rel_vec[win_idx]),
        .req_nbytes    (m_nbytes),
        .req_we        (m_we),
        .req_wdata     (m_wdata),
        .s_ready       (s_ready),
        .s_rdata       (s_rdata),
        .s_sel         (s_sel),
        .s_addr        (s_addr),
        .s_nbytes      (s_nbytes),
        .s_we          (s_we),
        .s_wdata       (s_wdata),
        .m_done        (m_done),
        .m_rdata       (m_rdata),
        .m_fault       (m_fault),
        .m_fault_cause (m_fault_cause)
    );

    assert_hit_inside_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ({1'b0, m_addr} < SPAN_END));
endmodule

// File: tb/bus_region_decoder_test.sv
module bus_region_decoder_test;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam int NR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_start = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [2:0] m_nbytes = 3'd1;
    logic m_we = 1'b0;
    logic [DW-1:0] m_wdata = '0;
    logic [DW-1:0] m_rdata;
    logic m_done, m_fault;
    logic [1:0] m_fault_cause;
    logic [NR-1:0] s_sel;
    logic [AW-1:0] s_addr;
    logic [2:0] s_nbytes;
    logic s_we;
    logic [DW-1:0] s_wdata;
    logic [NR*DW-1:0] s_rdata;
    logic [NR-1:0] s_ready;
    logic stall = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < NR; g++) begin : g_slv
        assign s_rdata[g*DW +: DW] = {4'hC, 4'(g), s_addr};
    end
    assign s_ready = stall ? '0 : s_sel;

    bus_region_decoder uut (
        .clk(clk), .rst_n(rst_n), .m_start(m_start), .m_addr(m_addr),
        .m_nbytes(m_nbytes), .m_we(m_we), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_done(m_done), .m_fault(m_fault), .m_fault_cause(m_fault_cause),
        .s_sel(s_sel), .s_addr(s_addr), .s_nbytes(s_nbytes), .s_we(s_we),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ready(s_ready)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [AW-1:0] a, input logic [2:0] n,
                         input logic w, input logic [DW-1:0] d);
        @(negedge clk);
        m_addr = a; m_nbytes = n; m_we = w; m_wdata = d; m_start = 1'b1;
        @(negedge clk);
        m_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 sel", 64'(s_sel), 0);
        chk("R1 done", 64'(m_done), 0);
        chk("R1 fault", 64'(m_fault), 0);
        chk("R1 cause", 64'(m_fault_cause), 0);
    endtask

    // legal access, optionally stalled, optionally with an extra start mid-access
    task automatic t_access(input logic [AW-1:0] a, input logic [2:0] n, input logic w,
                            input logic [DW-1:0] d, input int idx, input logic [AW-1:0] rel,
                            input int hold, input string tag);
        stall = (hold > 0);
        pulse(a, n, w, d);
        chk({tag, " R2 sel"}, 64'(s_sel), 64'(1 << idx));
        chk({tag, " R3 rel"}, 64'(s_addr), 64'(rel));
        chk({tag, " R3 nbytes"}, 64'(s_nbytes), 64'(n));
        chk({tag, " R9 we"}, 64'(s_we), 64'(w));
        if (w) chk({tag, " R9 wdata"}, 64'(s_wdata), 64'(d));
        for (int k = 0; k < hold; k++) begin
            if (k == 0) begin
                m_addr = 24'h000004; m_nbytes = 3'd1; m_start = 1'b1;
                @(negedge clk);
                m_start = 1'b0;
                chk({tag, " R10 addr kept"}, 64'(s_addr), 64'(rel));
                chk({tag, " R10 sel kept"}, 64'(s_sel), 64'(1 << idx));
            end else begin
                @(negedge clk);
                chk({tag, " R8 hold sel"}, 64'(s_sel), 64'(1 << idx));
            end
            chk({tag, " R8 no early done"}, 64'(m_done), 0);
        end
        stall = 1'b0;
        @(negedge clk);
        chk({tag, " R8 done"}, 64'(m_done), 1);
        chk({tag, " R8 rdata"}, 64'(m_rdata), 64'({4'hC, 4'(idx), rel}));
        chk({tag, " R8 sel dropped"}, 64'(s_sel), 0);
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, 64'(m_done), 0);
    endtask

    task automatic t_fault(input logic [AW-1:0] a, input logic [2:0] n,
                           input logic [1:0] cause, input string tag);
        pulse(a, n, 1'b0, '0);
        chk({tag, " R7 fault"}, 64'(m_fault), 1);
        chk({tag, " cause"}, 64'(m_fault_cause), 64'(cause));
        chk({tag, " no sel"}, 64'(s_sel), 0);
        @(negedge clk);
        chk({tag, " R7 fault one cycle"}, 64'(m_fault), 0);
        chk({tag, " R7 cause cleared"}, 64'(m_fault_cause), 0);
        chk({tag, " no done"}, 64'(m_done), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_access(24'h000000, 3'd1, 1'b0, '0, 0, 24'h000000, 0, "rom first");
        t_access(24'h00FFFC, 3'd4, 1'b0, '0, 0, 24'h00FFFC, 0, "rom top");
        t_access(24'h1FFFFC, 3'd4, 1'b0, '0, 1, 24'h0FFFFC, 0, "ram top");
        t_access(24'h100010, 3'd2, 1'b1, 32'hDEAD_BEEF, 1, 24'h000010, 0, "ram write");
        t_access(24'h70000F, 3'd1, 1'b0, '0, 2, 24'h00000F, 0, "io last");
        t_access(24'h70000E, 3'd2, 1'b1, 32'h0000_5A5A, 2, 24'h00000E, 3, "io stalled");
        t_fault(24'h1FFFFE, 3'd4, 2'd2, "R4 ram overrun");
        t_fault(24'h70000F, 3'd2, 2'd2, "R4 io overrun");
        t_fault(24'h00FFFF, 3'd2, 2'd2, "R4 rom overrun");
        t_fault(24'h010000, 3'd1, 2'd1, "R5 gap after rom");
        t_fault(24'h0FFFFF, 3'd1, 2'd1, "R5 below ram");
        t_fault(24'h700010, 3'd1, 2'd1, "R5 past span");
        t_fault(24'h100000, 3'd3, 2'd3, "R6 len3");
        t_fault(24'h300000, 3'd0, 2'd3, "R6 len0 unmapped");
        t_access(24'h180000, 3'd4, 1'b0, '0, 1, 24'h080000, 1, "ram after faults");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R8 actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule